// File: doc/BRIEF.md
# Layered Offset Min-Sum Check Unit

This block performs the check-node update of one parity-check row for a horizontally layered LDPC decoder. A row begins with a start pulse. The pulse carries the row's degree and the slot in a local message store that belongs to the row. The posterior LLRs of the row's variable nodes then arrive one per accepted cycle. For each one, the unit subtracts the check-to-variable message that the same row left for that edge on its previous visit. The result is the 7-bit variable-to-check value, which is kept in a small edge buffer. While the values arrive, the unit tracks the two smallest magnitudes, the position of the smallest, and the parity of all signs.

After the last input, the unit enters an output pass. It streams one edge per cycle, in arrival order. Each edge carries the new 5-bit check message, computed by offset min-sum, and the refreshed 5-bit LLR. The new message replaces the old one in the store, ready for the row's next visit. A one-cycle done pulse follows the last edge. The interleaving network, the block memories, the code tables and the iteration control sit outside this block.

All LLRs and messages are two's complement values on a common scale, with 2 fractional bits.

Top module: `chk_node_unit`

## Requirements
- R1: After reset, busy_o, out_valid_o and done_o are low. Every stored check message is zero, so the first visit of any row subtracts nothing.
- R2: A start pulse is accepted only while busy_o is low, row_deg_i is between 2 and MAX_DEG inclusive, and row_sel_i is below ROWS. Any other start pulse is ignored: busy_o stays low, or the row in progress continues unchanged. An accepted start raises busy_o on the next cycle.
- R3: Each accepted input forms the variable-to-check value T = llr_i − E_old, as a signed 7-bit value clipped to ±63. The 5-bit input llr_i covers the full range −16..15. E_old is the message stored for that row slot and that edge position.
- R4: Over a row, the unit keeps the smallest |T| and the second smallest |T|. The position of the smallest is its first occurrence. A value equal to the current smallest becomes the second smallest, so tied minima give every edge the same magnitude.
- R5: An edge's new message magnitude is max(m − 1, 0), capped at 15. Here m is the second minimum for the edge at the stored minimum position, and the first minimum for every other edge.
- R6: An edge's new message sign is the XOR of all sign bits of T in the row, XOR that edge's own sign bit. A T of zero counts as positive, and a negative result is emitted as the two's complement negation.
- R7: An edge's new LLR is T + E_new, clipped to ±15. The output LLR is never −16.
- R8: The new message lies in ±15 and is written to the row slot at that edge position. The next visit of the same row subtracts it, and the other row slots are not affected.
- R9: The output pass presents exactly row_deg_i edges on consecutive cycles, in arrival order. It starts on the cycle after the last input is accepted. done_o is high for exactly the one cycle that follows the last edge, and busy_o falls on the cycle after that.
- R10: llr_valid_i is ignored outside the input phase. During the input phase, cycles with llr_valid_i low stall the row without changing its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Row start pulse |
| row_sel_i | input | ROW_W | Message store slot of the row, sampled with start_i |
| row_deg_i | input | DEG_W | Row degree, sampled with start_i |
| llr_valid_i | input | 1 | Qualifies llr_i during the input phase |
| llr_i | input | LLR_W | Incoming posterior LLR, two's complement |
| busy_o | output | 1 | A row is in progress |
| out_valid_o | output | 1 | llr_o and emsg_o carry an edge result |
| llr_o | output | LLR_W | Updated LLR for the current output edge |
| emsg_o | output | EMN_W | New check-to-variable message for the current output edge |
| done_o | output | 1 | One-cycle pulse after the last output edge |

## Verification
The bench builds the unit with MAX_DEG = 8 and ROWS = 2, keeping the default 5/7/5 widths and an offset of one step. With two slots, rows alternate and the stored messages of one slot must survive the other slot's traffic. With degree 2, every one of the 1024 pairs of 5-bit inputs can be driven, which covers every tie, every zero and both clip limits. Degrees 3 to 8 are then swept with pseudo-random and extreme values, with stall cycles, stray valid pulses and ignored start pulses mixed in.

// File: rtl/cnu_pkg.sv
package cnu_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_COLLECT = 2'd1,
      ST_EMIT    = 2'd2,
      ST_DONE    = 2'd3
   } cnu_state_t;

   // symmetric clip to [-lim, lim]
   function automatic int clip_sym(input int v, input int lim);
      if (v > lim)  return lim;
      if (v < -lim) return -lim;
      return v;
   endfunction

endpackage

// File: rtl/cnu_msg_store.sv
module cnu_msg_store #(
   parameter int ROWS    = 4,
   parameter int MAX_DEG = 32,
   parameter int W       = 5,
   parameter int ROW_W   = 2,
   parameter int IDX_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ROW_W-1:0] rd_row,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [W-1:0]     rd_data,
   input  logic             wr_en,
   input  logic [ROW_W-1:0] wr_row,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [W-1:0]     wr_data
);

   logic [W-1:0] mem [ROWS][MAX_DEG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++)
            for (int e = 0; e < MAX_DEG; e++)
               mem[r][e] <= '0;
      end else if (wr_en) begin
         mem[wr_row][wr_idx] <= wr_data;
      end
   end

   generate
      if (ROWS == 1) begin : g_one_row
         assign rd_data = mem[0][rd_idx];
      end else begin : g_multi_row
         assign rd_data = mem[rd_row][rd_idx];
      end
   endgenerate

endmodule

// File: rtl/cnu_min_tracker.sv
module cnu_min_tracker #(
   parameter int MAG_W = 6,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             upd,
   input  logic [IDX_W-1:0] idx,
   input  logic [MAG_W-1:0] mag,
   input  logic             sgn,
   output logic [MAG_W-1:0] min1,
   output logic [MAG_W-1:0] min2,
   output logic [IDX_W-1:0] min_idx,
   output logic             parity
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         min1    <= '1;
         min2    <= '1;
         min_idx <= '0;
         parity  <= 1'b0;
      end else if (clear) begin
         min1    <= '1;
         min2    <= '1;
         min_idx <= '0;
         parity  <= 1'b0;
      end else if (upd) begin
         parity <= parity ^ sgn;
         if (mag < min1) begin
            min2    <= min1;
            min1    <= mag;
            min_idx <= idx;
         end else if (mag < min2) begin
            min2 <= mag;
         end
      end
   end

endmodule

// File: rtl/cnu_edge_out.sv
module cnu_edge_out
   import cnu_pkg::*;
#(
   parameter int TNM_W  = 7,
   parameter int EMN_W  = 5,
   parameter int LLR_W  = 5,
   parameter int MAG_W  = 6,
   parameter int IDX_W  = 5,
   parameter int OFFSET = 1
) (
   input  logic [TNM_W-1:0] tnm,
   input  logic [IDX_W-1:0] edge_idx,
   input  logic [MAG_W-1:0] min1,
   input  logic [MAG_W-1:0] min2,
   input  logic [IDX_W-1:0] min_idx,
   input  logic             parity,
   output logic [EMN_W-1:0] emsg,
   output logic [LLR_W-1:0] llr
);

   localparam int EMN_MAX = 2**(EMN_W-1) - 1;
   localparam int LLR_MAX = 2**(LLR_W-1) - 1;

   logic [MAG_W-1:0] sel;
   logic [MAG_W-1:0] red;
   logic [MAG_W-1:0] capped;
   logic             sgn;

   assign sel = (edge_idx == min_idx) ? min2 : min1;

   generate
      if (OFFSET == 0) begin : g_plain
         assign red = sel;
      end else begin : g_offset
         assign red = (sel > MAG_W'(OFFSET)) ? (sel - MAG_W'(OFFSET)) : '0;
      end
   endgenerate

   assign capped = (int'(red) > EMN_MAX) ? MAG_W'(EMN_MAX) : red;
   assign sgn    = parity ^ tnm[TNM_W-1];

   always_comb begin
      int m;
      int e;
      int s;
      m    = int'(capped);
      e    = sgn ? -m : m;
      emsg = EMN_W'(e);
      s    = int'($signed(tnm)) + e;
      llr  = LLR_W'(clip_sym(s, LLR_MAX));
   end

endmodule

// File: rtl/chk_node_unit.sv
module chk_node_unit
   import cnu_pkg::*;
#(
   parameter int LLR_W   = 5,
   parameter int TNM_W   = 7,
   parameter int EMN_W   = 5,
   parameter int MAX_DEG = 32,
   parameter int ROWS    = 4,
   parameter int OFFSET  = 1,
   localparam int IDX_W  = (MAX_DEG > 1) ? $clog2(MAX_DEG) : 1,
   localparam int DEG_W  = $clog2(MAX_DEG + 1),
   localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [ROW_W-1:0] row_sel_i,
   input  logic [DEG_W-1:0] row_deg_i,
   input  logic             llr_valid_i,
   input  logic [LLR_W-1:0] llr_i,
   output logic             busy_o,
   output logic             out_valid_o,
   output logic [LLR_W-1:0] llr_o,
   output logic [EMN_W-1:0] emsg_o,
   output logic             done_o
);

   localparam int MAG_W   = TNM_W - 1;
   localparam int TNM_MAX = 2**(TNM_W-1) - 1;

   generate
      if (MAX_DEG < 2) begin : g_bad_deg
         $error("chk_node_unit: MAX_DEG must be at least 2");
      end
      if (ROWS < 1) begin : g_bad_rows
         $error("chk_node_unit: ROWS must be at least 1");
      end
      if (TNM_W <= LLR_W || TNM_W <= EMN_W) begin : g_bad_tnm
         $error("chk_node_unit: TNM_W must exceed LLR_W and EMN_W");
      end
   endgenerate

   cnu_state_t       state;
   logic [IDX_W-1:0] cnt;
   logic [DEG_W-1:0] deg_q;
   logic [ROW_W-1:0] row_q;
   logic [TNM_W-1:0] tbuf [MAX_DEG];

   logic             accept;
   logic             take;
   logic             emit;
   logic             last;
   logic [EMN_W-1:0] old_msg;
   logic [TNM_W-1:0] tnm_new;
   logic [MAG_W-1:0] tnm_mag;
   logic [TNM_W-1:0] tnm_cur;
   logic [MAG_W-1:0] min1, min2;
   logic [IDX_W-1:0] min_idx;
   logic             parity;

   assign accept = (state == ST_IDLE) && start_i &&
                   (row_deg_i >= DEG_W'(2)) && (row_deg_i <= DEG_W'(MAX_DEG)) &&
                   (int'(row_sel_i) < ROWS);
   assign take   = (state == ST_COLLECT) && llr_valid_i;
   assign emit   = (state == ST_EMIT);
   assign last   = (int'(cnt) == int'(deg_q) - 1);

   // variable-to-check value
   always_comb begin
      int d;
      d       = int'($signed(llr_i)) - int'($signed(old_msg));
      tnm_new = TNM_W'(clip_sym(d, TNM_MAX));
      tnm_mag = tnm_new[TNM_W-1] ? MAG_W'(-tnm_new) : MAG_W'(tnm_new);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         deg_q <= '0;
         row_q <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  state <= ST_COLLECT;
                  cnt   <= '0;
                  deg_q <= row_deg_i;
                  row_q <= row_sel_i;
               end
            end
            ST_COLLECT: begin
               if (llr_valid_i) begin
                  if (last) begin
                     state <= ST_EMIT;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_EMIT: begin
               if (last) begin
                  state <= ST_DONE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (take) tbuf[cnt] <= tnm_new;
   end

   assign tnm_cur = tbuf[cnt];

   cnu_msg_store #(
      .ROWS(ROWS), .MAX_DEG(MAX_DEG), .W(EMN_W), .ROW_W(ROW_W), .IDX_W(IDX_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_row  (row_q),
      .rd_idx  (cnt),
      .rd_data (old_msg),
      .wr_en   (emit),
      .wr_row  (row_q),
      .wr_idx  (cnt),
      .wr_data (emsg_o)
   );

   cnu_min_tracker #(
      .MAG_W(MAG_W), .IDX_W(IDX_W)
   ) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .upd     (take),
      .idx     (cnt),
      .mag     (tnm_mag),
      .sgn     (tnm_new[TNM_W-1]),
      .min1    (min1),
      .min2    (min2),
      .min_idx (min_idx),
      .parity  (parity)
   );

   cnu_edge_out #(
      .TNM_W(TNM_W), .EMN_W(EMN_W), .LLR_W(LLR_W),
      .MAG_W(MAG_W), .IDX_W(IDX_W), .OFFSET(OFFSET)
   ) u_out (
      .tnm      (tnm_cur),
      .edge_idx (cnt),
      .min1     (min1),
      .min2     (min2),
      .min_idx  (min_idx),
      .parity   (parity),
      .emsg     (emsg_o),
      .llr      (llr_o)
   );

   assign busy_o      = (state != ST_IDLE);
   assign out_valid_o = emit;
   assign done_o      = (state == ST_DONE);

endmodule

// File: rtl/cnu_props.sv
module cnu_props #(
   parameter int LLR_W   = 5,
   parameter int EMN_W   = 5,
   parameter int MAX_DEG = 32,
   parameter int ROWS    = 4,
   parameter int DEG_W   = 6,
   parameter int ROW_W   = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [ROW_W-1:0] row_sel_i,
   input logic [DEG_W-1:0] row_deg_i,
   input logic             busy_o,
   input logic             out_valid_o,
   input logic [LLR_W-1:0] llr_o,
   input logic [EMN_W-1:0] emsg_o,
   input logic             done_o
);

   logic             acc;
   logic [DEG_W-1:0] deg_lat;
   logic [DEG_W:0]   ocnt;

   assign acc = start_i && !busy_o &&
                (row_deg_i >= DEG_W'(2)) && (row_deg_i <= DEG_W'(MAX_DEG)) &&
                (int'(row_sel_i) < ROWS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         deg_lat <= '0;
         ocnt    <= '0;
      end else if (acc) begin
         deg_lat <= row_deg_i;
         ocnt    <= '0;
      end else if (out_valid_o) begin
         ocnt <= ocnt + 1'b1;
      end
   end

   a_r2_accept_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> busy_o);

   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!out_valid_o && !done_o));

   a_r7_llr_not_min_code: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> (llr_o != {1'b1, {(LLR_W-1){1'b0}}}));

   a_r8_msg_not_min_code: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> (emsg_o != {1'b1, {(EMN_W-1){1'b0}}}));

   a_r9_done_after_output: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(out_valid_o));

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r9_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (ocnt == {1'b0, deg_lat}));

   a_r9_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

endmodule

bind chk_node_unit cnu_props #(
   .LLR_W(LLR_W), .EMN_W(EMN_W), .MAX_DEG(MAX_DEG), .ROWS(ROWS),
   .DEG_W(DEG_W), .ROW_W(ROW_W)
) u_props (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .row_sel_i   (row_sel_i),
   .row_deg_i   (row_deg_i),
   .busy_o      (busy_o),
   .out_valid_o (out_valid_o),
   .llr_o       (llr_o),
   .emsg_o      (emsg_o),
   .done_o      (done_o)
);

// File: tb/chk_node_unit_test.sv
module chk_node_unit_test;

   localparam int MD    = 8;
   localparam int NR    = 2;
   localparam int DEG_W = 4;
   localparam int ROW_W = 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [ROW_W-1:0] row_sel_i = '0;
   logic [DEG_W-1:0] row_deg_i = '0;
   logic             llr_valid_i = 1'b0;
   logic [4:0]       llr_i = '0;
   logic             busy_o, out_valid_o, done_o;
   logic [4:0]       llr_o, emsg_o;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int mrf [NR][MD];
   logic [31:0] seed = 32'h1234_5678;

   always #5 clk = ~clk;

   chk_node_unit #(.MAX_DEG(MD), .ROWS(NR)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .row_sel_i(row_sel_i),
      .row_deg_i(row_deg_i), .llr_valid_i(llr_valid_i), .llr_i(llr_i),
      .busy_o(busy_o), .out_valid_o(out_valid_o), .llr_o(llr_o),
      .emsg_o(emsg_o), .done_o(done_o)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         failures = failures + 1;
         checks = checks + 1;
         $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   function automatic int clip(input int v, input int lim);
      if (v > lim) return lim;
      if (v < -lim) return -lim;
      return v;
   endfunction

   function automatic int rnd5();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'($signed(seed[20:16]));
   endfunction

   // one full row, model computed from the requirements
   task automatic run_row(input int row, input int deg, input int v[MD],
                          input bit gap, input bit noise);
      int tn[MD];
      int m1, m2, ix, par, a, m, s, e, l;
      int exp_e[MD];
      int exp_l[MD];
      m1 = 63; m2 = 63; ix = 0; par = 0;
      for (int k = 0; k < deg; k++) begin
         tn[k] = clip(v[k] - mrf[row][k], 63);                  // R3
         a = (tn[k] < 0) ? -tn[k] : tn[k];
         if (a < m1) begin m2 = m1; m1 = a; ix = k; end          // R4
         else if (a < m2) m2 = a;
         par ^= (tn[k] < 0) ? 1 : 0;
      end
      for (int k = 0; k < deg; k++) begin
         m = (k == ix) ? m2 : m1;                                // R5
         m = m - 1; if (m < 0) m = 0; if (m > 15) m = 15;
         s = par ^ ((tn[k] < 0) ? 1 : 0);                        // R6
         e = s ? -m : m;
         l = clip(tn[k] + e, 15);                                // R7
         exp_e[k] = e; exp_l[k] = l;
      end
      @(negedge clk);
      start_i = 1'b1; row_sel_i = ROW_W'(row); row_deg_i = DEG_W'(deg);
      llr_valid_i = noise; llr_i = 5'(rnd5());                    // R10 idle valid ignored
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
      for (int k = 0; k < deg; k++) begin
         if (gap && k == 1) begin
            llr_valid_i = 1'b0; llr_i = 5'(rnd5());               // R10 stall
            @(negedge clk);
         end
         llr_valid_i = 1'b1; llr_i = 5'(v[k]);
         @(negedge clk);
      end
      llr_valid_i = noise; llr_i = 5'(rnd5());
      for (int k = 0; k < deg; k++) begin
         if (noise && k == 0) begin
            start_i = 1'b1; row_sel_i = ROW_W'(row ^ 1); row_deg_i = DEG_W'(3); // R2 ignored while busy
         end else begin
            start_i = 1'b0;
         end
         chk(out_valid_o == 1'b1, "R9 out_valid", int'(out_valid_o), 1);
         chk(int'($signed(emsg_o)) == exp_e[k], "R5/R6/R8 emsg",
             int'($signed(emsg_o)), exp_e[k]);
         chk(int'($signed(llr_o)) == exp_l[k], "R7 llr", int'($signed(llr_o)), exp_l[k]);
         @(negedge clk);
      end
      start_i = 1'b0; llr_valid_i = 1'b0;
      chk(done_o == 1'b1 && out_valid_o == 1'b0, "R9 done pulse", int'(done_o), 1);
      @(negedge clk);
      chk(done_o == 1'b0 && busy_o == 1'b0, "R9 back to idle", int'(busy_o), 0);
      for (int k = 0; k < deg; k++) mrf[row][k] = exp_e[k];     // R8 write back
   endtask

   initial begin
      int v[MD];
      for (int r = 0; r < NR; r++)
         for (int k = 0; k < MD; k++) mrf[r][k] = 0;             // R1 cleared store
      repeat (2) @(negedge clk);
      chk(busy_o == 1'b0 && out_valid_o == 1'b0 && done_o == 1'b0, "R1 reset outputs",
          int'(busy_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o == 1'b0 && out_valid_o == 1'b0 && done_o == 1'b0, "R1 idle after reset",
          int'(out_valid_o), 0);

      // R2: illegal degrees are ignored
      foreach (v[k]) v[k] = 0;
      for (int d = 0; d < 16; d++) begin
         if (d >= 2 && d <= MD) continue;
         @(negedge clk);
         start_i = 1'b1; row_deg_i = DEG_W'(d); row_sel_i = '0;
         @(negedge clk);
         start_i = 1'b0;
         chk(busy_o == 1'b0, "R2 bad degree ignored", int'(busy_o), 0);
      end

      // first visit uses zero stored messages (R1), then exhaustive degree-2 pairs
      for (int a = -16; a < 16; a++) begin
         for (int b = -16; b < 16; b++) begin
            v[0] = a; v[1] = b;
            run_row((a + b) & 1, 2, v, ((a ^ b) & 2) != 0, ((a + 2 * b) & 4) != 0);
         end
      end

      // degrees 3..MD, pseudo-random values
      for (int d = 3; d <= MD; d++) begin
         for (int n = 0; n < 60; n++) begin
            for (int k = 0; k < MD; k++) v[k] = rnd5();
            run_row(n & 1, d, v, n[1], n[2]);
         end
      end

      // extremes: clip limits, ties, zeros
      for (int n = 0; n < 24; n++) begin
         for (int k = 0; k < MD; k++) begin
            case (n % 4)
               0: v[k] = 15;
               1: v[k] = -16;
               2: v[k] = (k % 2) ? -4 : 4;
               default: v[k] = 0;
            endcase
         end
         run_row(n & 1, 2 + (n % (MD - 1)), v, n[0], n[1]);
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule